// File: doc/BRIEF.md
# Addressed Serial Command Packet Decoder

The block takes a stream of recovered link bits, one bit per cycle that `bit_valid_i` marks, and cuts it into packets. Each packet starts with an 8-bit address byte, then an 8-bit opcode, then a data field. All fields arrive MSB first. The opcode alone sets the data-field length, so the framer finds the packet end without any delimiter. The first valid bit after a packet ends opens the next one.

A packet acts on this device when its address is the broadcast value 00h, or when it equals the device's own ID, which resets to FFh. Some opcodes only take effect when broadcast. An accepted write packet loads one configuration register in a single step after its last bit: gray-scale levels, per-output dot correction, colour-tone values, plane brightness, tone control or operating mode. Other opcodes pulse an output instead: a soft reset, an HSYNC mark and end event, a read flag, or a load of the device ID.

Top module: `cmd_pkt_decoder`

## Requirements
- R1: A packet is 16 header bits (address in the first 8, opcode in the next 8), then the data bits. Only cycles with `bit_valid_i` high count as bits, and every field is MSB first. The first valid bit after a packet's last bit is the first address bit of the next packet, with no idle cycles required.
- R2: The data-field length in bits depends on the opcode: 00h→8, 02h→120, 04h→96, 08h→32, 10h→16, 20h→8, 40h→16, 50h→16, 60h→8, 70h→16, 80h→16.
- R3: A packet is accepted when its address is 00h, or when its address equals `dev_id_o`. `dev_id_o` resets to FFh. A packet that is not accepted changes no output.
- R4: Opcodes 00h, 70h and 80h take effect only when the address is 00h. If they carry an individual address, they are framed by their length and otherwise ignored.
- R5: An accepted 02h packet loads `gs_o` with all 120 data bits. The first data bit received lands in bit 119.
- R6: An accepted 04h packet loads `dc_o` with its 96 data bits. An accepted 08h packet loads `ct_o` with its 32 data bits. In both cases the first data bit received is the MSB.
- R7: Accepted packets with opcode 10h, 20h and 40h load `bright_o` (16 bits), `tone_ctl_o` (8 bits) and `mode_o` (16 bits) respectively.
- R8: Any opcode not listed in R2 has a data field of 0 bits. Such a packet changes no output.
- R9: A register write is atomic. The output holds its old value through the clock edge that samples the last bit and through the following cycle. The whole new value appears after the next edge.
- R10: A broadcast 00h packet pulses `soft_rst_o` for one cycle. It returns `gs_o`, `dc_o`, `ct_o`, `bright_o`, `tone_ctl_o`, `mode_o` and `hsync_data_o` to zero, and leaves `dev_id_o` unchanged.
- R11: A broadcast 70h packet loads `dev_id_o` from its last 8 data bits.
- R12: A broadcast 80h packet pulses `hsync_mark_o` for one cycle after its 21st bit is sampled. After the packet ends, it pulses `hsync_o` for one cycle and loads `hsync_data_o` with its 16 data bits.
- R13: An accepted 50h or 60h packet pulses `rd_o` for one cycle. `rd_sel_o` is 0 for 50h and 1 for 60h. No register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_valid_i | input | 1 | High when `bit_i` carries a link bit |
| bit_i | input | 1 | Recovered serial data bit |
| gs_o | output | 120 | Gray-scale levels, 10 bits for each of 12 outputs |
| dc_o | output | 96 | Dot correction, 8 bits for each of 12 outputs |
| ct_o | output | 32 | Colour-tone correction, 4 × 8 bits |
| bright_o | output | 16 | Plane brightness setting |
| tone_ctl_o | output | 8 | Colour-tone control |
| mode_o | output | 16 | Operating mode |
| dev_id_o | output | 8 | Current device ID |
| hsync_mark_o | output | 1 | Pulse after bit 21 of an HSYNC packet |
| hsync_o | output | 1 | Pulse at the end of an HSYNC packet |
| hsync_data_o | output | 16 | Data field of the last HSYNC packet |
| soft_rst_o | output | 1 | Soft reset pulse |
| rd_o | output | 1 | Read command flag |
| rd_sel_o | output | 1 | Read kind: 0 = output monitor, 1 = failure monitor |

## Verification
The dangerous internal fault is a bit counter that drifts from the true packet boundary. It shows at the ports only on the next packet, which then lands in the wrong register or carries a shifted value. For that reason, every write is followed at once by a packet of a different kind, sent with no gap. A wrong length in the opcode table shows the same way, one packet later. A bad address or broadcast-only check shows within two cycles of the packet end, as an unexpected register change or an unexpected pulse.

// File: rtl/pktdec_pkg.sv
package pktdec_pkg;
  localparam int unsigned ID_W   = 8;
  localparam int unsigned CMD_W  = 8;
  localparam int unsigned HDR_W  = ID_W + CMD_W;
  localparam int unsigned DATA_W = 120;
  localparam int unsigned CNT_W  = $clog2(HDR_W + DATA_W + 1);
  localparam int unsigned GS_W   = 120;
  localparam int unsigned DC_W   = 96;
  localparam int unsigned CT_W   = 32;
  localparam int unsigned BR_W   = 16;
  localparam int unsigned TC_W   = 8;
  localparam int unsigned MD_W   = 16;
  localparam int unsigned HS_W   = 16;
  localparam logic [ID_W-1:0]  BCAST_ID = '0;
  localparam logic [CMD_W-1:0] HSYNC_CMD = 8'h80;
  localparam int unsigned MARK_BIT = 20; // zero-based index of bit 21

  typedef enum logic [3:0] {
    K_RST, K_GS, K_DC, K_CT, K_BR, K_TC, K_MODE,
    K_RD_OVM, K_RD_FM, K_AID, K_HSYNC, K_NONE
  } kind_e;

  function automatic kind_e cmd_kind(logic [CMD_W-1:0] c);
    case (c)
      8'h00: return K_RST;
      8'h02: return K_GS;
      8'h04: return K_DC;
      8'h08: return K_CT;
      8'h10: return K_BR;
      8'h20: return K_TC;
      8'h40: return K_MODE;
      8'h50: return K_RD_OVM;
      8'h60: return K_RD_FM;
      8'h70: return K_AID;
      8'h80: return K_HSYNC;
      default: return K_NONE;
    endcase
  endfunction

  function automatic int unsigned kind_len(kind_e k);
    case (k)
      K_RST, K_TC, K_RD_FM:                   return 8;
      K_GS:                                   return GS_W;
      K_DC:                                   return DC_W;
      K_CT:                                   return CT_W;
      K_BR, K_MODE, K_RD_OVM, K_AID, K_HSYNC: return 16;
      default:                                return 0;
    endcase
  endfunction

  function automatic logic kind_bcast_only(kind_e k);
    return (k == K_RST) || (k == K_AID) || (k == K_HSYNC);
  endfunction
endpackage

// File: rtl/pktdec_framer.sv
module pktdec_framer
  import pktdec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  output logic              end_o,
  output logic              mark_o,
  output logic [ID_W-1:0]   id_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [DATA_W-1:0] data_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [HDR_W-1:0]  hdr_q;
  logic [DATA_W-1:0] dsr_q;
  logic              end_q, mark_q;
  logic [CMD_W-1:0]  cmd_cur;
  logic              last;

  // opcode becomes known on the 16th header bit
  assign cmd_cur = (cnt_q == CNT_W'(HDR_W - 1)) ? {hdr_q[CMD_W-2:0], bit_i}
                                                : hdr_q[CMD_W-1:0];
  assign last = bit_valid_i &&
                (cnt_q == CNT_W'(HDR_W - 1 + kind_len(cmd_kind(cmd_cur))));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hdr_q  <= '0;
      dsr_q  <= '0;
      end_q  <= 1'b0;
      mark_q <= 1'b0;
    end else begin
      end_q  <= last;
      mark_q <= bit_valid_i && (cnt_q == CNT_W'(MARK_BIT)) &&
                (hdr_q == {BCAST_ID, HSYNC_CMD});
      if (bit_valid_i) begin
        if (cnt_q < CNT_W'(HDR_W)) hdr_q <= {hdr_q[HDR_W-2:0], bit_i};
        else                       dsr_q <= {dsr_q[DATA_W-2:0], bit_i};
        cnt_q <= last ? '0 : cnt_q + 1'b1;
      end
    end
  end

  assign end_o  = end_q;
  assign mark_o = mark_q;
  assign id_o   = hdr_q[HDR_W-1:CMD_W];
  assign cmd_o  = hdr_q[CMD_W-1:0];
  assign data_o = dsr_q;

  a_r1_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(HDR_W + DATA_W - 1));
  a_r1_end_needs_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_q |-> $past(bit_valid_i));
  a_r12_mark_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_q |=> !mark_q);
endmodule

// File: rtl/pktdec_regs.sv
module pktdec_regs
  import pktdec_pkg::*;
#(
  parameter logic [ID_W-1:0] RESET_ID = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              end_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [GS_W-1:0]   gs_o,
  output logic [DC_W-1:0]   dc_o,
  output logic [CT_W-1:0]   ct_o,
  output logic [BR_W-1:0]   bright_o,
  output logic [TC_W-1:0]   tone_ctl_o,
  output logic [MD_W-1:0]   mode_o,
  output logic [ID_W-1:0]   dev_id_o,
  output logic              hsync_o,
  output logic [HS_W-1:0]   hsync_data_o,
  output logic              soft_rst_o,
  output logic              rd_o,
  output logic              rd_sel_o
);
  kind_e kind;
  logic  accept, wr;

  assign kind   = cmd_kind(cmd_i);
  assign accept = (id_i == BCAST_ID) ||
                  ((id_i == dev_id_o) && !kind_bcast_only(kind));
  assign wr     = end_i && accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gs_o <= '0; dc_o <= '0; ct_o <= '0; bright_o <= '0;
      tone_ctl_o <= '0; mode_o <= '0; hsync_data_o <= '0;
      dev_id_o <= RESET_ID;
      hsync_o <= 1'b0; soft_rst_o <= 1'b0; rd_o <= 1'b0; rd_sel_o <= 1'b0;
    end else begin
      hsync_o    <= wr && (kind == K_HSYNC);
      soft_rst_o <= wr && (kind == K_RST);
      rd_o       <= wr && ((kind == K_RD_OVM) || (kind == K_RD_FM));
      if (wr) begin
        case (kind)
          K_RST: begin
            gs_o <= '0; dc_o <= '0; ct_o <= '0; bright_o <= '0;
            tone_ctl_o <= '0; mode_o <= '0; hsync_data_o <= '0;
          end
          K_GS:     gs_o         <= data_i[GS_W-1:0];
          K_DC:     dc_o         <= data_i[DC_W-1:0];
          K_CT:     ct_o         <= data_i[CT_W-1:0];
          K_BR:     bright_o     <= data_i[BR_W-1:0];
          K_TC:     tone_ctl_o   <= data_i[TC_W-1:0];
          K_MODE:   mode_o       <= data_i[MD_W-1:0];
          K_AID:    dev_id_o     <= data_i[ID_W-1:0];
          K_HSYNC:  hsync_data_o <= data_i[HS_W-1:0];
          K_RD_OVM: rd_sel_o     <= 1'b0;
          K_RD_FM:  rd_sel_o     <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  a_r9_gs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !end_i |=> $stable(gs_o));
  a_r9_dc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !end_i |=> $stable(dc_o));
  a_r3_id_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !end_i |=> $stable(dev_id_o));
  a_r13_pulse_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({soft_rst_o, hsync_o, rd_o}));
endmodule

// File: rtl/cmd_pkt_decoder.sv
module cmd_pkt_decoder
  import pktdec_pkg::*;
#(
  parameter logic [7:0] RESET_ID = 8'hFF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_valid_i,
  input  logic         bit_i,
  output logic [119:0] gs_o,
  output logic [95:0]  dc_o,
  output logic [31:0]  ct_o,
  output logic [15:0]  bright_o,
  output logic [7:0]   tone_ctl_o,
  output logic [15:0]  mode_o,
  output logic [7:0]   dev_id_o,
  output logic         hsync_mark_o,
  output logic         hsync_o,
  output logic [15:0]  hsync_data_o,
  output logic         soft_rst_o,
  output logic         rd_o,
  output logic         rd_sel_o
);
  logic              pkt_end;
  logic [ID_W-1:0]   pkt_id;
  logic [CMD_W-1:0]  pkt_cmd;
  logic [DATA_W-1:0] pkt_data;

  pktdec_framer u_framer (
    .clk_i, .rst_ni, .bit_valid_i, .bit_i,
    .end_o(pkt_end), .mark_o(hsync_mark_o),
    .id_o(pkt_id), .cmd_o(pkt_cmd), .data_o(pkt_data)
  );

  pktdec_regs #(.RESET_ID(RESET_ID)) u_regs (
    .clk_i, .rst_ni,
    .end_i(pkt_end), .id_i(pkt_id), .cmd_i(pkt_cmd), .data_i(pkt_data),
    .gs_o, .dc_o, .ct_o, .bright_o, .tone_ctl_o, .mode_o, .dev_id_o,
    .hsync_o, .hsync_data_o, .soft_rst_o, .rd_o, .rd_sel_o
  );

  a_r12_mark_then_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_mark_o |-> !hsync_o);
endmodule

// File: tb/cmd_pkt_decoder_bench.sv
module cmd_pkt_decoder_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, bv = 1'b0, bd = 1'b0;
  logic [119:0] gs; logic [95:0] dc; logic [31:0] ct;
  logic [15:0] br, md, hsd; logic [7:0] tc, did;
  logic mark, hs, srst, rd, rsel;

  int nchk = 0, nfail = 0;
  bit done = 0;

  typedef struct packed { logic [2:0] k; logic [15:0] d; } ev_t;
  ev_t evq[$];

  logic [119:0] e_gs = '0; logic [95:0] e_dc = '0; logic [31:0] e_ct = '0;
  logic [15:0] e_br = '0, e_md = '0, e_hsd = '0; logic [7:0] e_tc = '0, e_id = 8'hFF;

  always #(CLK_P/2) clk = ~clk;

  cmd_pkt_decoder u_cmd_pkt_decoder (
    .clk_i(clk), .rst_ni(rst_n), .bit_valid_i(bv), .bit_i(bd),
    .gs_o(gs), .dc_o(dc), .ct_o(ct), .bright_o(br), .tone_ctl_o(tc),
    .mode_o(md), .dev_id_o(did), .hsync_mark_o(mark), .hsync_o(hs),
    .hsync_data_o(hsd), .soft_rst_o(srst), .rd_o(rd), .rd_sel_o(rsel)
  );

  task automatic check(string tag, logic [119:0] act, logic [119:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check({tag, " gs"}, gs, e_gs);
    check({tag, " dc"}, 120'(dc), 120'(e_dc));
    check({tag, " ct"}, 120'(ct), 120'(e_ct));
    check({tag, " bright"}, 120'(br), 120'(e_br));
    check({tag, " tone"}, 120'(tc), 120'(e_tc));
    check({tag, " mode"}, 120'(md), 120'(e_md));
    check({tag, " hsync_data"}, 120'(hsd), 120'(e_hsd));
    check({tag, " dev_id"}, 120'(did), 120'(e_id));
  endtask

  task automatic send_bit(logic b, int gap);
    @(negedge clk); bv = 1'b1; bd = b;
    @(negedge clk); bv = 1'b0; bd = 1'b0;
    for (int g = 1; g < gap; g++) @(negedge clk);
  endtask

  // sends all bits; when hold is set the final bit is left for the caller
  task automatic send_pkt(logic [7:0] id, logic [7:0] cmd, logic [119:0] d,
                          int nb, int gap, bit hold);
    logic [15:0] h = {id, cmd};
    for (int i = 15; i >= 0; i--) begin
      if (!(hold && nb == 0 && i == 0)) begin
        @(negedge clk); bv = 1'b1; bd = h[i];
        if (gap > 0) begin @(negedge clk); bv = 1'b0; for (int g = 1; g < gap; g++) @(negedge clk); end
      end
    end
    for (int i = nb - 1; i >= 0; i--) begin
      if (!(hold && i == 0)) begin
        @(negedge clk); bv = 1'b1; bd = d[i];
        if (gap > 0) begin @(negedge clk); bv = 1'b0; for (int g = 1; g < gap; g++) @(negedge clk); end
      end
    end
  endtask

  task automatic settle();
    @(negedge clk); bv = 1'b0; bd = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pop_cmp(logic [2:0] k, logic [15:0] d, string tag);
    ev_t e;
    nchk++;
    if (evq.size() == 0) begin
      nfail++;
      $display("FAIL %s unexpected event act=%0d exp=none", tag, k);
    end else begin
      e = evq.pop_front();
      if (e.k !== k || e.d !== d) begin
        nfail++;
        $display("FAIL %s event act=%0d/%h exp=%0d/%h", tag, k, d, e.k, e.d);
      end
    end
  endtask

  // monitor: 0 soft reset, 1 mark, 2 hsync end, 3 read ovm, 4 read fm
  always @(negedge clk) if (rst_n && !done) begin
    if (srst) pop_cmp(3'd0, 16'h0, "R10");
    if (mark) pop_cmp(3'd1, 16'h0, "R12");
    if (hs)   pop_cmp(3'd2, hsd, "R12");
    if (rd)   pop_cmp(rsel ? 3'd4 : 3'd3, 16'h0, "R13");
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    nfail++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [119:0] pat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R3 reset");
    check("R13 reset pulses", 120'({mark, hs, srst, rd}), 120'(0));

    // R5 broadcast gray-scale, then at once R1 back-to-back dot correction to FFh
    pat = {60'hA5F0_1234_5678_9AB, 60'h0FE_DCBA_9876_5432};
    send_pkt(8'h00, 8'h02, pat, 120, 0, 0);
    e_gs = pat;
    send_pkt(8'hFF, 8'h04, {24'h0, 96'hC3C3_0102_0304_0506_0708_090A}, 96, 0, 0);
    e_dc = 96'hC3C3_0102_0304_0506_0708_090A;
    settle();
    check_all("R5 R6 R1 gs+dc");

    // R3 non-matching address is framed and ignored
    send_pkt(8'h05, 8'h08, 120'hDEAD_BEEF, 32, 0, 0);
    settle();
    check_all("R3 mismatch ct");

    // R4 individual auto-ID ignored; R11 broadcast auto-ID loads 05h
    send_pkt(8'hFF, 8'h70, 120'h0033, 16, 0, 0);
    settle();
    check_all("R4 aid individual");
    send_pkt(8'h00, 8'h70, 120'h1205, 16, 0, 0);
    e_id = 8'h05;
    settle();
    check_all("R11 aid");

    // R6 colour tone to new ID with gaps in valid
    send_pkt(8'h05, 8'h08, 120'hDEAD_BEEF, 32, 2, 0);
    e_ct = 32'hDEAD_BEEF;
    settle();
    check_all("R6 ct gaps");

    // R7 brightness, tone control, mode back to back; R8 unknown opcode in between
    send_pkt(8'h05, 8'h10, 120'hBEA7, 16, 0, 0);
    send_pkt(8'h00, 8'h33, 120'h0, 0, 0, 0);
    send_pkt(8'h05, 8'h20, 120'h6C, 8, 0, 0);
    send_pkt(8'h00, 8'h40, 120'h81F3, 16, 1, 0);
    e_br = 16'hBEA7; e_tc = 8'h6C; e_md = 16'h81F3;
    settle();
    check_all("R7 R8 R2 bright/tone/mode");

    // R2 read opcodes with data fields; R13 pulses, no register change
    evq.push_back('{k: 3'd3, d: 16'h0});
    send_pkt(8'h05, 8'h50, 120'hFFFF, 16, 0, 0);
    evq.push_back('{k: 3'd4, d: 16'h0});
    send_pkt(8'h00, 8'h60, 120'hAA, 8, 0, 0);
    settle();
    check_all("R13 reads");
    check("R13 queue drained", 120'(evq.size()), 120'(0));

    // R4 individual HSYNC ignored; R12 broadcast HSYNC mark and end
    send_pkt(8'h05, 8'h80, 120'h1111, 16, 0, 0);
    settle();
    check_all("R4 hsync individual");
    evq.push_back('{k: 3'd1, d: 16'h0});
    evq.push_back('{k: 3'd2, d: 16'h4C2D});
    send_pkt(8'h00, 8'h80, 120'h4C2D, 16, 0, 0);
    e_hsd = 16'h4C2D;
    settle();
    check_all("R12 hsync");
    check("R12 queue drained", 120'(evq.size()), 120'(0));

    // R9 atomic gray-scale write timing
    pat = ~pat;
    send_pkt(8'h05, 8'h02, pat, 120, 0, 1);
    @(negedge clk);
    check("R9 before last bit", gs, e_gs);
    bv = 1'b1; bd = pat[0];
    @(negedge clk); bv = 1'b0; bd = 1'b0;
    check("R9 edge of last bit", gs, e_gs);
    @(negedge clk);
    check("R9 next cycle", gs, pat);
    e_gs = pat;
    repeat (2) @(negedge clk);

    // R4 individual soft reset ignored; R10 broadcast soft reset
    send_pkt(8'h05, 8'h00, 120'h00, 8, 0, 0);
    settle();
    check_all("R4 soft reset individual");
    evq.push_back('{k: 3'd0, d: 16'h0});
    send_pkt(8'h00, 8'h00, 120'h5A, 8, 0, 0);
    e_gs = '0; e_dc = '0; e_ct = '0; e_br = '0; e_tc = '0; e_md = '0; e_hsd = '0;
    settle();
    check_all("R10 soft reset");
    check("R10 queue drained", 120'(evq.size()), 120'(0));

    // R1 framing after reset: next packet still lands correctly
    send_pkt(8'h05, 8'h10, 120'h0F0F, 16, 0, 0);
    e_br = 16'h0F0F;
    settle();
    check_all("R1 after reset");

    finish_run();
  end
endmodule